// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits on the byte-wide receive stream of an Ethernet MAC. It raises a wake event when a frame carries the wake pattern: a synchronisation run of six 0xFF bytes, followed at once by sixteen back-to-back copies of the station's 48-bit address. The sync run can only count once the twelve destination and source address bytes have passed. The frame must also be addressed to this station, to the broadcast address or to any multicast group.

While the enable input is high, the block asks the MAC to hold back normal reception, through a blocking output, and it checks every frame. When the pattern is found, a sticky status flag is set. An interrupt pulse, a power-management pulse, or both, can mark the moment the flag first sets. The host drops the enable input to return the receive path to normal operation. It uses the clear input to reset the flag.

The matcher runs one byte at a time. If an address run breaks, the matcher hunts for a fresh sync run later in the same frame. A 0xFF byte that breaks the run is counted as the first byte of the new sync candidate.

Top module: `magic_wake_detect`

## Requirements
- R1: After reset, `wake_seen`, `irq_pulse` and `pme_pulse` are low.
- R2: `rx_block` equals `wake_en`. While `wake_en` is low, no frame sets `wake_seen`.
- R3: A frame is accepted if its first six bytes equal the station address (most significant byte first), or if bit 0 of its first byte is 1 (multicast or broadcast). Any other unicast destination never produces a detection.
- R4: Sync needs six consecutive 0xFF bytes at frame offset 12 or later (offset 0 is the start-of-frame byte). A 0xFF in bytes 0 to 11 never counts, and five 0xFF bytes are not enough.
- R5: After the sync, sixteen back-to-back copies of the station address, each sent most significant byte first, set `wake_seen`. The flag is visible one clock after the last address byte is sampled. Any number of ordinary bytes may come before the sync. A frame that ends before the sixteenth copy is complete gives no detection.
- R6: A byte that differs from the expected address byte aborts the run. Detection then needs a new six-byte sync later in the same frame. A breaking 0xFF byte counts as the first byte of that new sync.
- R7: More than six 0xFF bytes before the address run still form a valid sync.
- R8: `wake_seen` stays high until `status_clr` is asserted in a cycle with no new detection. A detection in the same cycle as `status_clr` leaves the flag set.
- R9: `irq_pulse` (when `irq_en` is high) and `pme_pulse` (when `pme_en` is high) each pulse for exactly one cycle, only when `wake_seen` goes from 0 to 1.
- R10: Matcher state is reset by each start-of-frame byte. Bytes with `rx_valid` high that fall outside a frame (after an end-of-frame byte and before the next start-of-frame byte) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_eof | input | 1 | The present byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| station_addr | input | 48 | Station address; bits 47:40 are sent first |
| wake_en | input | 1 | Enables detection and blocks normal reception |
| irq_en | input | 1 | Enables the interrupt pulse |
| pme_en | input | 1 | Enables the power-management pulse |
| status_clr | input | 1 | Clears the sticky received flag |
| wake_seen | output | 1 | Sticky flag: a wake pattern was received |
| irq_pulse | output | 1 | One-cycle interrupt on a new detection |
| pme_pulse | output | 1 | One-cycle power-management event on a new detection |
| rx_block | output | 1 | Tells the MAC to discard normal receive traffic |

## Verification
The hardest behaviour to reach from the ports is recovery from a broken address run, because the break can fall on any of the 96 address bytes. The stimulus sweeps a bad byte across every position of the run. Each broken frame is sent once with a fresh sync after the break, where a detection is expected, and once without one, where none is expected. A second sweep breaks the run with 0xFF at each copy boundary. It follows the break with five more 0xFF bytes, which completes a sync only if the breaking byte is counted, and also with four, which must not complete one.

// File: rtl/magic_wake_pkg.sv
package magic_wake_pkg;

  localparam int unsigned OCTET_W = 8;
  localparam logic [OCTET_W-1:0] SYNC_OCTET = 8'hFF;

  typedef enum logic [1:0] {
    MS_HUNT  = 2'd0,
    MS_ARMED = 2'd1,
    MS_RUN   = 2'd2
  } match_state_e;

endpackage

// File: rtl/mwd_frame_track.sv
module mwd_frame_track #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HDR_LEN    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid,
  input  logic                      rx_sof,
  input  logic                      rx_eof,
  input  logic [7:0]                rx_data,
  input  logic [ADDR_BYTES*8-1:0]   station_addr,
  output logic                      byte_go,
  output logic                      frame_start,
  output logic                      payload,
  output logic                      dest_ok
);
  localparam int unsigned OFF_W = $clog2(HDR_LEN + 1);
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(HDR_LEN);
  localparam int NA = int'(ADDR_BYTES);

  logic [OFF_W-1:0] off_q, off_d, cur_off;
  logic             in_frame_q, in_frame_d;
  logic             uni_q, uni_d, grp_q, grp_d;
  logic [7:0]       dest_exp;
  int               didx;

  always_comb begin
    byte_go     = rx_valid & (rx_sof | in_frame_q);
    frame_start = rx_valid & rx_sof;
    cur_off     = rx_sof ? '0 : off_q;
    payload     = (cur_off == OFF_MAX);
    dest_ok     = uni_q | grp_q;
    didx        = (int'(cur_off) < NA) ? int'(cur_off) : 0;
    dest_exp    = station_addr[(NA - 1 - didx)*8 +: 8];

    in_frame_d = in_frame_q;
    off_d      = off_q;
    uni_d      = uni_q;
    grp_d      = grp_q;
    if (byte_go) begin
      in_frame_d = ~rx_eof;
      off_d      = (cur_off == OFF_MAX) ? cur_off : cur_off + 1'b1;
      if (int'(cur_off) < NA) begin
        uni_d = ((cur_off == '0) ? 1'b1 : uni_q) & (rx_data == dest_exp);
        if (cur_off == '0) grp_d = rx_data[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q      <= '0;
      in_frame_q <= 1'b0;
      uni_q      <= 1'b0;
      grp_q      <= 1'b0;
    end else if (byte_go) begin
      off_q      <= off_d;
      in_frame_q <= in_frame_d;
      uni_q      <= uni_d;
      grp_q      <= grp_d;
    end
  end

  assert_offset_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= OFF_MAX);

  assert_outside_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame_q && !rx_sof) |=> $stable(off_q));

endmodule

// File: rtl/mwd_seq_match.sv
module mwd_seq_match
  import magic_wake_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned SYNC_LEN   = 6,
  parameter int unsigned COPIES     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      frame_start,
  input  logic                      byte_go,
  input  logic                      payload,
  input  logic                      dest_ok,
  input  logic [7:0]                rx_data,
  input  logic [ADDR_BYTES*8-1:0]   station_addr,
  output logic                      hit
);
  localparam int unsigned FF_W  = $clog2(SYNC_LEN + 1);
  localparam int unsigned IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int unsigned CPY_W = (COPIES > 1) ? $clog2(COPIES) : 1;
  localparam logic [FF_W-1:0]  FF_LAST  = FF_W'(SYNC_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);
  localparam logic [CPY_W-1:0] CPY_LAST = CPY_W'(COPIES - 1);
  localparam int NA = int'(ADDR_BYTES);

  match_state_e     st_q, st_d;
  logic [FF_W-1:0]  ff_q, ff_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CPY_W-1:0] cpy_q, cpy_d;
  logic [7:0]       exp_byte;
  logic             is_sync, is_exp, step;

  always_comb begin
    exp_byte = station_addr[(NA - 1 - int'(idx_q))*8 +: 8];
    is_sync  = (rx_data == SYNC_OCTET);
    is_exp   = (rx_data == exp_byte);
    step     = byte_go & payload & dest_ok & enable;

    st_d  = st_q;
    ff_d  = ff_q;
    idx_d = idx_q;
    cpy_d = cpy_q;
    hit   = 1'b0;

    if (frame_start || !enable) begin
      st_d  = MS_HUNT;
      ff_d  = '0;
      idx_d = '0;
      cpy_d = '0;
    end else if (step) begin
      unique case (st_q)
        MS_HUNT: begin
          if (is_sync) begin
            if (ff_q == FF_LAST) begin
              st_d = MS_ARMED;
              ff_d = '0;
            end else begin
              ff_d = ff_q + 1'b1;
            end
          end else begin
            ff_d = '0;
          end
        end
        MS_ARMED: begin
          if (is_exp) begin
            st_d  = MS_RUN;
            idx_d = IDX_W'(1);
            cpy_d = '0;
          end else if (!is_sync) begin
            st_d = MS_HUNT;
            ff_d = '0;
          end
        end
        MS_RUN: begin
          if (is_exp) begin
            if (idx_q == IDX_LAST) begin
              idx_d = '0;
              if (cpy_q == CPY_LAST) begin
                hit   = 1'b1;
                st_d  = MS_HUNT;
                cpy_d = '0;
              end else begin
                cpy_d = cpy_q + 1'b1;
              end
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            st_d  = MS_HUNT;
            idx_d = '0;
            cpy_d = '0;
            ff_d  = is_sync ? FF_W'(1) : '0;
          end
        end
        default: begin
          st_d = MS_HUNT;
          ff_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_HUNT;
      ff_q  <= '0;
      idx_q <= '0;
      cpy_q <= '0;
    end else if (frame_start || !enable || step) begin
      st_q  <= st_d;
      ff_q  <= ff_d;
      idx_q <= idx_d;
      cpy_q <= cpy_d;
    end
  end

  assert_hit_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> enable);

  assert_hit_needs_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> dest_ok);

  assert_sync_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ff_q <= FF_LAST);

  assert_hit_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (st_q == MS_RUN));

  assert_sof_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (st_q == MS_HUNT && cpy_q == '0));

endmodule

// File: rtl/mwd_event.sv
module mwd_event (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic status_clr,
  input  logic irq_en,
  input  logic pme_en,
  output logic wake_seen,
  output logic irq_pulse,
  output logic pme_pulse
);
  logic seen_q, seen_d, irq_q, irq_d, pme_q, pme_d, first;

  always_comb begin
    first  = hit & ~seen_q;
    seen_d = hit | (seen_q & ~status_clr);
    irq_d  = first & irq_en;
    pme_d  = first & pme_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      irq_q  <= 1'b0;
      pme_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      irq_q  <= irq_d;
      pme_q  <= pme_d;
    end
  end

  assign wake_seen = seen_q;
  assign irq_pulse = irq_q;
  assign pme_pulse = pme_q;

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_seen && !status_clr) |=> wake_seen);

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_pme_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pme_pulse |=> !pme_pulse);

  assert_irq_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $rose(wake_seen));

  assert_pme_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pme_pulse |-> $rose(wake_seen));

endmodule

// File: rtl/magic_wake_detect.sv
module magic_wake_detect #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned SYNC_LEN   = 6,
  parameter int unsigned COPIES     = 16,
  parameter int unsigned HDR_LEN    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic [ADDR_BYTES*8-1:0] station_addr,
  input  logic                    wake_en,
  input  logic                    irq_en,
  input  logic                    pme_en,
  input  logic                    status_clr,
  output logic                    wake_seen,
  output logic                    irq_pulse,
  output logic                    pme_pulse,
  output logic                    rx_block
);
  logic byte_go, frame_start, payload, dest_ok, hit;

  mwd_frame_track #(.ADDR_BYTES(ADDR_BYTES), .HDR_LEN(HDR_LEN)) u_track (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .station_addr(station_addr),
    .byte_go(byte_go), .frame_start(frame_start), .payload(payload),
    .dest_ok(dest_ok)
  );

  mwd_seq_match #(.ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN), .COPIES(COPIES)) u_match (
    .clk(clk), .rst_n(rst_n), .enable(wake_en), .frame_start(frame_start),
    .byte_go(byte_go), .payload(payload), .dest_ok(dest_ok),
    .rx_data(rx_data), .station_addr(station_addr), .hit(hit)
  );

  mwd_event u_event (
    .clk(clk), .rst_n(rst_n), .hit(hit), .status_clr(status_clr),
    .irq_en(irq_en), .pme_en(pme_en), .wake_seen(wake_seen),
    .irq_pulse(irq_pulse), .pme_pulse(pme_pulse)
  );

  assign rx_block = wake_en;

endmodule

// File: tb/magic_wake_detect_test.sv
module magic_wake_detect_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rx_valid, rx_sof, rx_eof, wake_en, irq_en, pme_en, status_clr;
  logic [7:0]  rx_data;
  logic [47:0] station;
  logic wake_seen, irq_pulse, pme_pulse, rx_block;

  int checks = 0, errors = 0, irq_cnt = 0, pme_cnt = 0;
  logic irq_prev = 1'b0, pme_prev = 1'b0;
  logic [7:0] fb [0:255];
  int fl = 0;

  magic_wake_detect uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .station_addr(station),
    .wake_en(wake_en), .irq_en(irq_en), .pme_en(pme_en),
    .status_clr(status_clr), .wake_seen(wake_seen), .irq_pulse(irq_pulse),
    .pme_pulse(pme_pulse), .rx_block(rx_block)
  );

  always @(negedge clk) begin
    if (irq_pulse) irq_cnt++;
    if (pme_pulse) pme_cnt++;
    if (irq_pulse && irq_prev) begin
      errors++; $display("FAIL R9 irq_pulse width act=2 exp=1");
    end
    if (pme_pulse && pme_prev) begin
      errors++; $display("FAIL R9 pme_pulse width act=2 exp=1");
    end
    irq_prev = irq_pulse;
    pme_prev = pme_pulse;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ab(input int i);
    return station[(5 - (i % 6))*8 +: 8];
  endfunction

  task automatic push(input logic [7:0] b); fb[fl] = b; fl++; endtask
  task automatic push_ff(input int n); for (int i = 0; i < n; i++) push(8'hFF); endtask
  task automatic push_copies(input int n); for (int i = 0; i < n*6; i++) push(ab(i)); endtask

  // kind 0: station, 1: broadcast, 2: multicast, 3: foreign unicast
  task automatic push_hdr(input int kind);
    fl = 0;
    for (int i = 0; i < 6; i++) begin
      case (kind)
        0: push(ab(i));
        1: push(8'hFF);
        2: push((i == 0) ? 8'h01 : 8'h5E);
        default: push((i == 0) ? 8'h02 : 8'h33);
      endcase
    end
    for (int i = 0; i < 6; i++) push(8'h0A + 8'(i));
  endtask

  task automatic send_frame(input bit clr_last, input bit no_eof);
    for (int i = 0; i < fl; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == fl-1) && !no_eof;
      rx_data = fb[i]; status_clr = clr_last && (i == fl-1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; status_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_status;
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
  endtask

  task automatic try_frame(input string req, input logic exp);
    clear_status;
    send_frame(1'b0, 1'b0);
    chk(req, wake_seen, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int i0, i1;
    rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    wake_en = 1'b0; irq_en = 1'b0; pme_en = 1'b0; status_clr = 1'b0;
    station = 48'h00_11_22_33_44_55;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wake_seen", wake_seen, 0);
    chk("R1 irq_pulse", irq_pulse, 0);
    chk("R1 pme_pulse", pme_pulse, 0);

    // R2: disabled path
    chk("R2 rx_block low", rx_block, 0);
    push_hdr(0); push_ff(6); push_copies(16);
    try_frame("R2 disabled no detect", 0);
    wake_en = 1'b1;
    @(negedge clk);
    chk("R2 rx_block high", rx_block, 1);

    // R3: destination kinds
    for (int k = 0; k < 4; k++) begin
      push_hdr(k); push_ff(6); push_copies(16);
      try_frame($sformatf("R3 dest kind %0d", k), (k != 3));
    end

    // R4: 0xFF only in header bytes, and sync length sweep (R7 above six)
    push_hdr(1); for (int i = 6; i < 12; i++) fb[i] = 8'hFF; push_copies(16);
    try_frame("R4 header FF not sync", 0);
    for (int n = 0; n <= 10; n++) begin
      push_hdr(0); push_ff(n); push_copies(16);
      try_frame($sformatf("R4 R7 sync len %0d", n), (n >= 6));
    end

    // R5: leading filler, copy count, early end
    for (int pad = 0; pad <= 20; pad += 4) begin
      push_hdr(2); for (int i = 0; i < pad; i++) push(8'h5A);
      push_ff(6); push_copies(16);
      try_frame($sformatf("R5 offset pad %0d", pad), 1);
    end
    for (int n = 14; n <= 16; n++) begin
      push_hdr(0); push_ff(6); push_copies(n);
      try_frame($sformatf("R5 copies %0d", n), (n == 16));
    end
    push_hdr(0); push_ff(6); push_copies(15);
    for (int i = 0; i < 5; i++) push(ab(i));
    try_frame("R5 last copy short", 0);

    // R6: break at every run position
    for (int p = 0; p < 96; p++) begin
      for (int v = 0; v < 2; v++) begin
        push_hdr(0); push_ff(6);
        for (int j = 0; j < p; j++) push(ab(j));
        push(8'h77);
        if (v == 0) push_ff(6);
        push_copies(16);
        try_frame($sformatf("R6 break pos %0d resync %0d", p, (v == 0)), (v == 0));
      end
    end
    // R6: breaking 0xFF counts toward new sync
    for (int k = 1; k < 16; k++) begin
      for (int v = 0; v < 2; v++) begin
        push_hdr(0); push_ff(6); push_copies(k);
        push_ff(v == 0 ? 6 : 5);
        push_copies(16);
        try_frame($sformatf("R6 ff break copy %0d len %0d", k, (v == 0) ? 6 : 5), (v == 0));
      end
    end

    // R10: start-of-frame resets state; bytes outside frames ignored
    clear_status;
    push_hdr(0); push_ff(6); push_copies(8);
    send_frame(1'b0, 1'b1);
    push_hdr(0); push_copies(8);
    send_frame(1'b0, 1'b0);
    chk("R10 sof resets run", wake_seen, 0);
    push_hdr(0); push_ff(6); push_copies(16);
    for (int i = 0; i < fl; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = fb[i];
    end
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 loose bytes ignored", wake_seen, 0);

    // R8: sticky, clear, set wins over clear
    push_hdr(0); push_ff(6); push_copies(16);
    try_frame("R8 detect", 1);
    repeat (5) @(negedge clk);
    chk("R8 held", wake_seen, 1);
    clear_status;
    @(negedge clk);
    chk("R8 cleared", wake_seen, 0);
    send_frame(1'b1, 1'b0);
    chk("R8 set wins", wake_seen, 1);

    // R9: enable combinations and no pulse while already set
    for (int e = 0; e < 4; e++) begin
      irq_en = e[0]; pme_en = e[1];
      i0 = irq_cnt; i1 = pme_cnt;
      push_hdr(0); push_ff(6); push_copies(16);
      try_frame("R9 detect", 1);
      chk($sformatf("R9 irq count en %0d", e[0]), irq_cnt - i0, e[0]);
      chk($sformatf("R9 pme count en %0d", e[1]), pme_cnt - i1, e[1]);
      i0 = irq_cnt; i1 = pme_cnt;
      send_frame(1'b0, 1'b0);
      chk("R9 no irq while set", irq_cnt - i0, 0);
      chk("R9 no pme while set", pme_cnt - i1, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule